// File: doc/BRIEF.md
# TCP Connection Record Classifier

This block sits behind a TCP header parser in a stream-reassembly pipeline. For every parsed header it hashes the directional four-tuple (source address, destination address, source port, destination port) into an index. It reads the connection record stored at that index in an on-block synchronous RAM. It then decides what happens to the packet and writes the updated record back. The record keeps the four-tuple, the next expected sequence number, three handshake flags (established, SYN seen, ACK seen), a buffer pointer and a small saved application state.

The result is a 3-bit action code. The code tells downstream logic whether to forward the packet to both the application and the network, send it to the network only as a retransmission, buffer it as out of order, drop it, pass it through as an unknown flow, or treat it as a newly opened connection. On a buffering decision the block also reports the connection's buffer pointer. Each lookup is a fixed two-cycle read-modify-write. While a lookup is in flight, the input is held off. After reset the block clears every record before it accepts its first header.

Top module: `tcp_conn_classifier`

## Requirements
- R1: After reset, `in_ready` and `out_valid` are low. `in_ready` stays low for exactly 2^HASH_W clock cycles while every record is cleared, and then rises.
- R2: A header is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low during the next cycle. `out_valid` is high for exactly one cycle, starting at the second rising edge after acceptance, and is low at all other times.
- R3: The record index is the XOR-fold of the 96-bit tuple {src_ip, dst_ip, src_port, dst_port}, with dst_port in the least significant bits. Tuple bit i is folded into index bit (i mod HASH_W). Two tuples with equal folds share one record.
- R4: A header with `in_csum_err` high gives action DROP (code 0) and leaves the record unchanged.
- R5: A SYN that reaches a record whose established flag is clear gives action OPEN (code 5). The record then stores the tuple, sets the established and SYN flags, takes its ACK flag from `in_ack`, sets the expected sequence to seq+1, and has a null buffer pointer.
- R6: A SYN whose tuple differs from the stored tuple of an established record takes the record over (action OPEN, same update as R5) if the stored ACK flag is clear. If the stored ACK flag is set, the SYN gives DROP and the record is unchanged.
- R7: A SYN whose tuple matches an established record gives action RETX (code 2) and leaves the record unchanged.
- R8: A non-SYN header with `in_ack` high that matches an established record sets the stored ACK flag.
- R9: A non-SYN header that matches an established record and whose sequence equals the expected value gives action FWD (code 1). The expected value then advances by the payload length; for example, (seq 1, len 10) followed by (seq 11, len 20) leaves 31.
- R10: For a matching non-SYN header, seq − expected is taken modulo 2^32. A nonzero difference with bit 31 set gives RETX and leaves the expected value unchanged. A nonzero difference with bit 31 clear gives BUFFER (code 3).
- R11: On BUFFER with a null pointer, the record takes the next value of an allocator. The allocator starts at 1 after reset, adds 1 per allocation and skips 0 on wrap. Later BUFFER results for the connection report the same pointer. `out_buf_ptr` is nonzero on BUFFER and zero for every other action.
- R12: A non-SYN header that reaches a record whose established flag is clear, or whose stored tuple differs, gives action UNKNOWN (code 4) and leaves the record unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Block can accept a header this cycle |
| in_src_ip | input | 32 | Source IPv4 address |
| in_dst_ip | input | 32 | Destination IPv4 address |
| in_src_port | input | 16 | Source port |
| in_dst_port | input | 16 | Destination port |
| in_seq | input | 32 | Sequence number |
| in_len | input | LEN_W | Payload length in bytes |
| in_syn | input | 1 | SYN flag |
| in_ack | input | 1 | ACK flag |
| in_csum_err | input | 1 | Checksum failed upstream |
| out_valid | output | 1 | Action result strobe |
| out_action | output | 3 | Action code |
| out_buf_ptr | output | PTR_W | Buffer pointer on BUFFER, else zero |

## Verification
A wrong expected-sequence value or a wrong flag in a record is not visible when it is written. It shows up at the next header that hashes to the same index. That header gets a shifted FWD/RETX/BUFFER split, or a SYN collision gets OPEN where DROP is due, two cycles after it is accepted. The reference model in the bench therefore tracks every record and the pointer allocator, and it compares the action stream on every clock. It uses colliding tuples and sequence values around the 32-bit wrap, so that stale or corrupted state reaches the ports within a few packets.

// File: rtl/tcp_cls_pkg.sv
package tcp_cls_pkg;

   localparam int TUP_W = 96;
   localparam int SEQ_W = 32;

   typedef enum logic [2:0] {
      ACT_DROP = 3'd0,
      ACT_FWD  = 3'd1,
      ACT_RETX = 3'd2,
      ACT_BUF  = 3'd3,
      ACT_UNK  = 3'd4,
      ACT_OPEN = 3'd5
   } act_e;

   typedef struct packed {
      logic [TUP_W-1:0] tup;
      logic [SEQ_W-1:0] nxt;
      logic             est;
      logic             syn;
      logic             ack;
   } conn_core_t;

   localparam int CORE_W = $bits(conn_core_t);

endpackage

// File: rtl/tcp_cls_hash.sv
module tcp_cls_hash
   import tcp_cls_pkg::*;
#(
   parameter int HASH_W = 8,
   parameter int MODE   = 0
) (
   input  logic [TUP_W-1:0]  tuple_i,
   output logic [HASH_W-1:0] index_o
);
   localparam int NCH   = (TUP_W + HASH_W - 1) / HASH_W;
   localparam int PAD_W = NCH * HASH_W;

   logic [PAD_W-1:0]  padded;
   logic [HASH_W-1:0] part [NCH];

   assign padded = PAD_W'(tuple_i);

   for (genvar g = 0; g < NCH; g++) begin : g_slice
      localparam int ROT = g % HASH_W;
      if (MODE == 0 || ROT == 0) begin : g_plain
         assign part[g] = padded[g*HASH_W +: HASH_W];
      end else begin : g_rot
         assign part[g] = {padded[g*HASH_W +: HASH_W-ROT],
                           padded[g*HASH_W+HASH_W-ROT +: ROT]};
      end
   end

   always_comb begin
      index_o = '0;
      for (int k = 0; k < NCH; k++) index_o = index_o ^ part[k];
   end

endmodule

// File: rtl/tcp_cls_store.sv
module tcp_cls_store #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 160
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              init_busy
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] init_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_busy <= 1'b1;
         init_addr <= '0;
      end else if (init_busy) begin
         init_addr <= init_addr + 1'b1;
         if (init_addr == ADDR_W'(DEPTH - 1)) init_busy <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (init_busy)  mem[init_addr] <= '0;
      else if (wr_en) mem[wr_addr]   <= wr_data;
      if (rd_en)      rd_data        <= mem[rd_addr];
   end

   // R1: the clearing sweep runs once per reset
   assert_init_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !init_busy |=> !init_busy);

   // R1: no lookup or update competes with the sweep
   assert_no_access_in_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
      init_busy |-> !(rd_en || wr_en));

endmodule

// File: rtl/tcp_cls_decide.sv
module tcp_cls_decide
   import tcp_cls_pkg::*;
#(
   parameter int LEN_W = 16,
   parameter int PTR_W = 12,
   parameter int APP_W = 8
) (
   input  logic [TUP_W-1:0] pkt_tup,
   input  logic [SEQ_W-1:0] pkt_seq,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             pkt_syn,
   input  logic             pkt_ack,
   input  logic             pkt_csum,
   input  conn_core_t       rec_core,
   input  logic [PTR_W-1:0] rec_ptr,
   input  logic [APP_W-1:0] rec_app,
   input  logic [PTR_W-1:0] alloc_ptr,
   output act_e             act,
   output logic             wr,
   output conn_core_t       new_core,
   output logic [PTR_W-1:0] new_ptr,
   output logic [APP_W-1:0] new_app,
   output logic             take,
   output logic [PTR_W-1:0] res_ptr
);
   logic             match;
   logic [SEQ_W-1:0] diff;

   assign match = (rec_core.tup == pkt_tup);
   assign diff  = pkt_seq - rec_core.nxt;

   always_comb begin
      act      = ACT_DROP;
      wr       = 1'b0;
      new_core = rec_core;
      new_ptr  = rec_ptr;
      new_app  = rec_app;
      take     = 1'b0;
      res_ptr  = '0;
      if (pkt_csum) begin
         act = ACT_DROP;
      end else if (pkt_syn) begin
         if (!rec_core.est || (!match && !rec_core.ack)) begin
            act          = ACT_OPEN;
            wr           = 1'b1;
            new_core.tup = pkt_tup;
            new_core.est = 1'b1;
            new_core.syn = 1'b1;
            new_core.ack = pkt_ack;
            new_core.nxt = pkt_seq + 1'b1;
            new_ptr      = '0;
            new_app      = '0;
         end else if (match) begin
            act = ACT_RETX;
         end else begin
            act = ACT_DROP;
         end
      end else if (!rec_core.est || !match) begin
         act = ACT_UNK;
      end else begin
         wr = 1'b1;
         if (pkt_ack) new_core.ack = 1'b1;
         if (diff == '0) begin
            act          = ACT_FWD;
            new_core.nxt = pkt_seq + SEQ_W'(pkt_len);
         end else if (diff[SEQ_W-1]) begin
            act = ACT_RETX;
         end else begin
            act = ACT_BUF;
            if (rec_ptr == '0) begin
               new_ptr = alloc_ptr;
               take    = 1'b1;
            end
            res_ptr = new_ptr;
         end
      end
   end

endmodule

// File: rtl/tcp_conn_classifier.sv
module tcp_conn_classifier
   import tcp_cls_pkg::*;
#(
   parameter int HASH_W    = 8,
   parameter int PTR_W     = 12,
   parameter int APP_W     = 8,
   parameter int LEN_W     = 16,
   parameter int HASH_MODE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [31:0]      in_src_ip,
   input  logic [31:0]      in_dst_ip,
   input  logic [15:0]      in_src_port,
   input  logic [15:0]      in_dst_port,
   input  logic [31:0]      in_seq,
   input  logic [LEN_W-1:0] in_len,
   input  logic             in_syn,
   input  logic             in_ack,
   input  logic             in_csum_err,
   output logic             out_valid,
   output logic [2:0]       out_action,
   output logic [PTR_W-1:0] out_buf_ptr
);
   localparam int REC_W   = CORE_W + PTR_W + APP_W;
   localparam int PTR_MAX = (1 << PTR_W) - 1;

   if (HASH_W < 4 || HASH_W > 20) begin : g_bad_hash
      $error("HASH_W must lie in 4..20");
   end
   if (PTR_W < 2 || PTR_W > 32) begin : g_bad_ptr
      $error("PTR_W must lie in 2..32");
   end
   if (LEN_W < 1 || LEN_W > SEQ_W) begin : g_bad_len
      $error("LEN_W must lie in 1..32");
   end
   if (HASH_MODE != 0 && HASH_MODE != 1) begin : g_bad_mode
      $error("HASH_MODE must be 0 or 1");
   end

   logic              busy, init_busy, accept;
   logic [TUP_W-1:0]  tuple_in, pk_tup;
   logic [HASH_W-1:0] hash_in, pk_idx;
   logic [SEQ_W-1:0]  pk_seq;
   logic [LEN_W-1:0]  pk_len;
   logic              pk_syn, pk_ack, pk_csum;
   logic [PTR_W-1:0]  alloc_q;
   logic [REC_W-1:0]  rd_word, wr_word;

   conn_core_t        rec_core, new_core;
   logic [PTR_W-1:0]  rec_ptr, new_ptr, dec_ptr;
   logic [APP_W-1:0]  rec_app, new_app;
   act_e              dec_act;
   logic              dec_wr, dec_take;

   assign in_ready = !busy && !init_busy;
   assign accept   = in_valid && in_ready;
   assign tuple_in = {in_src_ip, in_dst_ip, in_src_port, in_dst_port};

   tcp_cls_hash #(.HASH_W(HASH_W), .MODE(HASH_MODE)) u_hash (
      .tuple_i (tuple_in),
      .index_o (hash_in)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         pk_tup  <= '0;
         pk_idx  <= '0;
         pk_seq  <= '0;
         pk_len  <= '0;
         pk_syn  <= 1'b0;
         pk_ack  <= 1'b0;
         pk_csum <= 1'b0;
      end else begin
         busy <= accept;
         if (accept) begin
            pk_tup  <= tuple_in;
            pk_idx  <= hash_in;
            pk_seq  <= in_seq;
            pk_len  <= in_len;
            pk_syn  <= in_syn;
            pk_ack  <= in_ack;
            pk_csum <= in_csum_err;
         end
      end
   end

   tcp_cls_store #(.ADDR_W(HASH_W), .DATA_W(REC_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (accept),
      .rd_addr   (hash_in),
      .rd_data   (rd_word),
      .wr_en     (busy && dec_wr),
      .wr_addr   (pk_idx),
      .wr_data   (wr_word),
      .init_busy (init_busy)
   );

   assign rec_core = conn_core_t'(rd_word[CORE_W-1:0]);
   assign rec_ptr  = rd_word[CORE_W +: PTR_W];
   assign rec_app  = rd_word[CORE_W+PTR_W +: APP_W];
   assign wr_word  = {new_app, new_ptr, new_core};

   tcp_cls_decide #(.LEN_W(LEN_W), .PTR_W(PTR_W), .APP_W(APP_W)) u_decide (
      .pkt_tup   (pk_tup),
      .pkt_seq   (pk_seq),
      .pkt_len   (pk_len),
      .pkt_syn   (pk_syn),
      .pkt_ack   (pk_ack),
      .pkt_csum  (pk_csum),
      .rec_core  (rec_core),
      .rec_ptr   (rec_ptr),
      .rec_app   (rec_app),
      .alloc_ptr (alloc_q),
      .act       (dec_act),
      .wr        (dec_wr),
      .new_core  (new_core),
      .new_ptr   (new_ptr),
      .new_app   (new_app),
      .take      (dec_take),
      .res_ptr   (dec_ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alloc_q <= PTR_W'(1);
      end else if (busy && dec_take) begin
         alloc_q <= (alloc_q == PTR_W'(PTR_MAX)) ? PTR_W'(1) : alloc_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_action  <= ACT_DROP;
         out_buf_ptr <= '0;
      end else begin
         out_valid <= busy;
         if (busy) begin
            out_action  <= dec_act;
            out_buf_ptr <= dec_ptr;
         end
      end
   end

   // R2: no second lookup while one is in flight
   assert_stall_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !in_ready);

   // R2: fixed two-cycle result latency
   assert_result_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ##1 out_valid);

   // R2: result strobe is a single cycle
   assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R4: checksum failures never leave as anything but DROP
   assert_csum_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && pk_csum) |-> (out_action == ACT_DROP));

   // R11: buffering always reports a real pointer
   assert_buf_ptr_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_action == ACT_BUF) |-> (out_buf_ptr != '0));

   // R11: pointer port quiet for other actions
   assert_ptr_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_action != ACT_BUF) |-> (out_buf_ptr == '0));

   // R11: allocator never hands out the null pointer
   assert_alloc_nonnull_R11: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_q != '0);

endmodule

// File: tb/sim_tcp_conn_classifier.sv
module sim_tcp_conn_classifier;
   localparam int CLK_PERIOD = 10;
   localparam int HW   = 8;
   localparam int PW   = 12;
   localparam int LW   = 16;
   localparam int NREC = 1 << HW;

   localparam logic [2:0] A_DROP = 3'd0;
   localparam logic [2:0] A_FWD  = 3'd1;
   localparam logic [2:0] A_RETX = 3'd2;
   localparam logic [2:0] A_BUF  = 3'd3;
   localparam logic [2:0] A_UNK  = 3'd4;
   localparam logic [2:0] A_OPEN = 3'd5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [31:0]   in_src_ip = '0, in_dst_ip = '0, in_seq = '0;
   logic [15:0]   in_src_port = '0, in_dst_port = '0;
   logic [LW-1:0] in_len = '0;
   logic          in_syn = 1'b0, in_ack = 1'b0, in_csum_err = 1'b0;
   logic          out_valid;
   logic [2:0]    out_action;
   logic [PW-1:0] out_buf_ptr;

   tcp_conn_classifier #(.HASH_W(HW), .PTR_W(PW), .LEN_W(LW)) u0 (
      .clk, .rst_n, .in_valid, .in_ready, .in_src_ip, .in_dst_ip,
      .in_src_port, .in_dst_port, .in_seq, .in_len, .in_syn, .in_ack,
      .in_csum_err, .out_valid, .out_action, .out_buf_ptr
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit running = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int            due;
      logic [2:0]    act;
      logic [PW-1:0] ptr;
      string         req;
   } exp_t;
   exp_t q[$];

   // behavioural record model
   bit          m_est [NREC];
   bit          m_ack [NREC];
   bit [95:0]   m_tup [NREC];
   bit [31:0]   m_nxt [NREC];
   bit [PW-1:0] m_ptr [NREC];
   int unsigned m_alloc = 1;

   function automatic int fold(input bit [95:0] t);
      bit [HW-1:0] h = '0;
      for (int i = 0; i < 96; i++) h[i % HW] ^= t[i];
      return int'(h);
   endfunction

   task automatic check(input bit ok, input string req, input string msg);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s", req, msg);
      end
   endtask

   task automatic model(input bit [95:0] t, input bit [31:0] seq, input bit [LW-1:0] len,
                        input bit syn, input bit ack, input bit csum,
                        output logic [2:0] act, output logic [PW-1:0] ptr);
      int h;
      bit [31:0] d;
      h = fold(t);
      ptr = '0;
      if (csum) act = A_DROP;
      else if (syn) begin
         if (!m_est[h] || (m_tup[h] != t && !m_ack[h])) begin
            act = A_OPEN;
            m_est[h] = 1; m_ack[h] = ack; m_tup[h] = t;
            m_nxt[h] = seq + 1; m_ptr[h] = '0;
         end else if (m_tup[h] == t) act = A_RETX;
         else act = A_DROP;
      end else if (!m_est[h] || m_tup[h] != t) act = A_UNK;
      else begin
         if (ack) m_ack[h] = 1;
         d = seq - m_nxt[h];
         if (d == 0) begin
            act = A_FWD;
            m_nxt[h] = seq + 32'(len);
         end else if (d[31]) act = A_RETX;
         else begin
            act = A_BUF;
            if (m_ptr[h] == '0) begin
               m_ptr[h] = PW'(m_alloc);
               m_alloc = (m_alloc == (1 << PW) - 1) ? 1 : m_alloc + 1;
            end
            ptr = m_ptr[h];
         end
      end
   endtask

   task automatic send(input bit [95:0] t, input bit [31:0] seq, input bit [LW-1:0] len,
                       input bit syn, input bit ack, input bit csum, input string req);
      exp_t e;
      @(negedge clk);
      {in_src_ip, in_dst_ip, in_src_port, in_dst_port} = t;
      in_seq = seq; in_len = len; in_syn = syn; in_ack = ack; in_csum_err = csum;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      model(t, seq, len, syn, ack, csum, e.act, e.ptr);
      e.due = cyc + 2;
      e.req = req;
      q.push_back(e);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(in_ready == 1'b0, "R2", $sformatf("in_ready=%0b expected 0 after accept", in_ready));
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (running) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (out_valid !== 1'b1 || out_action !== e.act || out_buf_ptr !== e.ptr) begin
               errors++;
               $display("FAIL %s: valid=%0b act=%0d ptr=%0d expected valid=1 act=%0d ptr=%0d",
                        e.req, out_valid, out_action, out_buf_ptr, e.act, e.ptr);
            end
         end else begin
            checks++;
            if (out_valid !== 1'b0) begin
               errors++;
               $display("FAIL R2: valid=%0b expected 0 (no result due)", out_valid);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL R2: watchdog expired, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      bit [95:0] ta, tb, tc;
      bit [95:0] pool [4];
      int cnt;
      for (int i = 0; i < NREC; i++) begin
         m_est[i] = 0; m_ack[i] = 0; m_tup[i] = '0; m_nxt[i] = '0; m_ptr[i] = '0;
      end
      ta = {32'h0A00_0001, 32'h0A00_0002, 16'd1000, 16'd80};
      tb = ta ^ 96'h0101;               // same fold as ta (R3)
      tc = {32'hC0A8_0101, 32'hC0A8_0202, 16'd4444, 16'd443};
      check(fold(ta) == fold(tb), "R3", "colliding tuples fold alike");

      repeat (3) @(negedge clk);
      check(in_ready == 1'b0 && out_valid == 1'b0, "R1",
            $sformatf("in_ready=%0b out_valid=%0b expected 0 0 in reset", in_ready, out_valid));
      rst_n = 1'b1;
      cnt = 0;
      while (!in_ready && cnt < NREC + 10) begin
         @(negedge clk);
         cnt++;
      end
      check(cnt == NREC, "R1", $sformatf("clear took %0d cycles expected %0d", cnt, NREC));
      running = 1'b1;

      send(ta, 32'd0, 0, 1, 0, 1, "R4");   // checksum error on SYN
      send(ta, 32'd5, 4, 0, 0, 0, "R12");  // still unknown: record untouched
      send(ta, 32'd0, 0, 1, 0, 0, "R5");   // open, expected 1
      send(ta, 32'd1, 10, 0, 0, 0, "R9");
      send(ta, 32'd11, 20, 0, 0, 0, "R9");
      send(ta, 32'd31, 0, 0, 0, 0, "R9");  // expected is 31
      send(ta, 32'd30, 5, 0, 0, 0, "R10"); // below: retransmission
      send(ta, 32'd40, 8, 0, 0, 0, "R11"); // first out of order: pointer 1
      send(ta, 32'd50, 8, 0, 0, 0, "R11"); // reuse pointer 1
      send(ta, 32'd31, 9, 0, 0, 0, "R9");  // in order again, expected 40
      send(ta, 32'd0, 0, 1, 0, 0, "R7");   // duplicate SYN
      send(tb, 32'd700, 0, 1, 0, 0, "R6"); // takeover, ACK clear
      send(ta, 32'd40, 3, 0, 0, 0, "R12"); // tuple now differs
      send(tb, 32'd701, 6, 0, 1, 0, "R8"); // sets ACK
      send(ta, 32'd9, 0, 1, 0, 0, "R6");   // collision blocked by ACK
      send(tb, 32'd707, 4, 0, 0, 1, "R4"); // dropped, no advance
      send(tb, 32'd707, 4, 0, 0, 0, "R4"); // same packet accepted in order
      send(tc, 32'hFFFF_FFF0, 0, 1, 1, 0, "R5");
      send(tc, 32'hFFFF_FFF1, 16'h20, 0, 1, 0, "R9");
      send(tc, 32'hFFFF_FFF8, 4, 0, 0, 0, "R10"); // below across wrap
      send(tc, 32'h0000_0020, 4, 0, 0, 0, "R11"); // above: pointer 2

      pool[0] = ta; pool[1] = tb; pool[2] = tc;
      pool[3] = {32'h0101_0101, 32'h0202_0202, 16'd7, 16'd9};
      for (int n = 0; n < 400; n++) begin
         int k;
         int h;
         bit [31:0] s;
         k = int'($urandom % 4);
         h = fold(pool[k]);
         s = m_nxt[h] + 32'($urandom % 9) - 32'd4;
         send(pool[k], s, LW'($urandom % 16), ($urandom % 8) == 0, ($urandom % 2) == 1,
              ($urandom % 10) == 0, "R10 mixed");
      end

      repeat (4) @(negedge clk);
      check(q.size() == 0, "R2", $sformatf("pending=%0d expected 0", q.size()));
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule